// File: doc/BRIEF.md
# Marker-Skipping Column Segment Generator

This block turns a raw page access on an interleaved NAND layout into a list of (column, length) segments. In that layout every ECC step stores its data chunk and then its parity bytes right behind it. A few bad-block marker bytes sit at the head of the spare area, and no chunk may use them. The generator walks the steps in order. It moves any segment that lands in the spare area past the marker bytes. When a chunk begins in the main area and runs over the main/spare boundary, the generator cuts it into two segments and places the skip gap between them.

There are two modes, chosen at start. Payload mode lists the data chunks. Spare mode first lists the marker region itself, then every parity region. The last parity region is stretched to take in the free spare bytes that follow it. Segments leave through a valid/ready handshake, and a one-cycle done pulse closes each job. The generator does not move any data itself: a data mover downstream consumes the segments.

Top module: `skip_column_mapper`

## Requirements
- R1: In payload mode (`spare_mode`=0), chunk i begins at column i*(step_size+parity_bytes) and is step_size bytes long. A chunk that ends at or before page_size is emitted unchanged as one segment.
- R2: A chunk whose start column is greater than or equal to page_size is emitted with its column increased by skip_count. Its length is not changed.
- R3: A chunk that begins below page_size and ends beyond it is emitted as two segments. The first is (start, page_size−start). The second is (page_size+skip_count, remaining length).
- R4: In spare mode (`spare_mode`=1), the first segment is the marker region: column page_size, length skip_count.
- R5: In spare mode, parity region i begins at step_size + i*(step_size+parity_bytes) and is parity_bytes long for every step except the last. The R2 and R3 rules apply to these regions.
- R6: In spare mode, the last parity region has length page_size + spare_size − start − skip_count, so that it also covers the free spare bytes. The R2 and R3 rules apply to it.
- R7: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_col` and `seg_len` hold their values. The generator moves to the next segment only on a cycle in which both are high.
- R8: `done` is high for exactly one cycle, in the cycle after the last segment is accepted. `busy` is high from the cycle after start until that done cycle, inclusive, and `seg_valid` is low while `done` is high.
- R9: A `start` pulse while `busy` is high is ignored. Changes to the size inputs during a job do not alter the job in progress.
- R10: A step_count of zero in payload mode produces no segment, and `done` rises in the cycle after start. In spare mode it produces only the marker segment.
- R11: After reset, `busy`, `seg_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job; accepted only when idle |
| spare_mode | input | 1 | 0 = payload chunks, 1 = marker and parity regions |
| page_size | input | COL_W | Main-area size in bytes |
| spare_size | input | COL_W | Spare-area size in bytes |
| step_size | input | COL_W | Data bytes per ECC step |
| parity_bytes | input | COL_W | Parity bytes per ECC step |
| step_count | input | CNT_W | Number of ECC steps |
| skip_count | input | SKIP_W | Marker bytes at the head of the spare area |
| busy | output | 1 | A job is in progress |
| seg_valid | output | 1 | Segment on seg_col/seg_len is valid |
| seg_ready | input | 1 | Consumer accepts the segment |
| seg_col | output | COL_W | Segment start column |
| seg_len | output | COL_W | Segment length in bytes |
| done | output | 1 | One-cycle pulse at the end of a job |

## Verification
Ports alone can hardly reach the split of the final spare-mode region. It needs a geometry where the last parity start falls just below the main-area end and the stretched length carries it well past that end. The stimulus picks step and parity sizes so that step three (and, in a shorter job, the last step) starts two bytes before the boundary. A stall pattern on `seg_ready` then holds the split head and tail on the port, which checks that they stay stable. A second `start` with different sizes arrives in the middle of such a stalled job and must leave the segment stream untouched.

// File: rtl/skip_column_mapper_pkg.sv
// Shared types for the marker-skipping column segment generator.
package skip_column_mapper_pkg;

    // Sequencer states of the top module.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MARK  = 3'd1,
        ST_CHUNK = 3'd2,
        ST_TAIL  = 3'd3,
        ST_DONE  = 3'd4
    } map_state_e;

endpackage

// File: rtl/scm_chunk_gen.sv
// Chunk walker: keeps the step index and the running start column of the
// current chunk (data chunk in payload mode, parity region in spare mode).
// It emits the raw, unshifted start column and length.
// Assumes the configuration inputs stay stable while a job runs (the top
// latches them), and that step_cnt is non-zero whenever advance or is_last
// is used.
module scm_chunk_gen #(
    parameter int COL_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic             spare_mode,
    input  logic [COL_W-1:0] page_sz,
    input  logic [COL_W-1:0] spare_sz,
    input  logic [COL_W-1:0] step_sz,
    input  logic [COL_W-1:0] parity_sz,
    input  logic [CNT_W-1:0] step_cnt,
    input  logic [COL_W-1:0] skip_sz,
    input  logic [COL_W-1:0] load_step_sz,
    input  logic             load_spare_mode,
    output logic [COL_W-1:0] raw_pos,
    output logic [COL_W-1:0] raw_len,
    output logic             is_last
);

    logic [CNT_W-1:0] idx_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] stride;

    assign stride = step_sz + parity_sz;

    // Step index and start column: reset on load, move by one stride per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            base_q <= '0;
        end else if (load) begin
            idx_q  <= '0;
            base_q <= load_spare_mode ? load_step_sz : '0;
        end else if (advance) begin
            idx_q  <= idx_q + 1'b1;
            base_q <= base_q + stride;
        end
    end

    // Last-step flag and raw length; the last spare region takes in the free bytes.
    always_comb begin
        is_last = (idx_q == (step_cnt - 1'b1));
        raw_pos = base_q;
        if (!spare_mode)
            raw_len = step_sz;
        else if (is_last)
            raw_len = page_sz + spare_sz - base_q - skip_sz;
        else
            raw_len = parity_sz;
    end

endmodule

// File: rtl/scm_split.sv
// Boundary splitter: moves a chunk that lies in the spare area past the
// marker bytes, and cuts a chunk that crosses the main/spare boundary into
// a head ending at the boundary and a tail starting after the marker bytes.
// Purely combinational. Assumes pos + len fits in COL_W+1 bits.
module scm_split #(
    parameter int COL_W = 16
) (
    input  logic [COL_W-1:0] pos,
    input  logic [COL_W-1:0] len,
    input  logic [COL_W-1:0] page_sz,
    input  logic [COL_W-1:0] skip_sz,
    output logic [COL_W-1:0] head_col,
    output logic [COL_W-1:0] head_len,
    output logic [COL_W-1:0] tail_col,
    output logic [COL_W-1:0] tail_len,
    output logic             straddle
);

    localparam int SUM_W = COL_W + 1;

    logic [SUM_W-1:0] end_col;
    logic             in_spare;
    logic [COL_W-1:0] room;

    // Classify the chunk against the boundary and derive both pieces.
    always_comb begin
        end_col  = SUM_W'(pos) + SUM_W'(len);
        in_spare = (pos >= page_sz);
        straddle = !in_spare && (end_col > SUM_W'(page_sz));
        room     = page_sz - pos;
        head_col = in_spare ? pos + skip_sz : pos;
        head_len = straddle ? room : len;
        tail_col = page_sz + skip_sz;
        tail_len = len - room;
    end

    // A split keeps every byte: the head is not empty and head plus tail give the chunk length.
    always_comb begin
        if (straddle === 1'b1) begin
            assert_split_conserves_R3: assert ((head_len != '0) &&
                ((SUM_W'(head_len) + SUM_W'(tail_len)) == SUM_W'(len)))
                else $error("split pieces do not add up to the chunk length");
        end
    end

endmodule

// File: rtl/skip_column_mapper.sv
// Marker-skipping column segment generator (top).
// On start it latches the geometry and walks the ECC steps. In spare mode
// it first emits the marker region. Every chunk passes through the
// boundary splitter, so the top presents either one segment or a head
// followed by a tail. The segment holds until it is accepted. A one-cycle
// done pulse ends the job.
// Assumes a legal geometry: skip_count <= spare_size and all columns fit in COL_W.
module skip_column_mapper
    import skip_column_mapper_pkg::*;
#(
    parameter int COL_W  = 16,
    parameter int CNT_W  = 8,
    parameter int SKIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              spare_mode,
    input  logic [COL_W-1:0]  page_size,
    input  logic [COL_W-1:0]  spare_size,
    input  logic [COL_W-1:0]  step_size,
    input  logic [COL_W-1:0]  parity_bytes,
    input  logic [CNT_W-1:0]  step_count,
    input  logic [SKIP_W-1:0] skip_count,
    output logic              busy,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [COL_W-1:0]  seg_col,
    output logic [COL_W-1:0]  seg_len,
    output logic              done
);

    localparam int SUM_W = COL_W + 1;

    map_state_e       state_q, state_d;
    logic             spare_q;
    logic [COL_W-1:0] page_q, spare_sz_q, step_q, parity_q, skip_q;
    logic [CNT_W-1:0] cnt_q;

    logic             take_start, accept, advance;
    logic [COL_W-1:0] raw_pos, raw_len;
    logic             is_last;
    logic [COL_W-1:0] head_col, head_len, tail_col, tail_len;
    logic             straddle;

    assign take_start = (state_q == ST_IDLE) && start;
    assign accept     = seg_valid && seg_ready;

    // Latch the job geometry when a start is taken in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q    <= 1'b0;
            page_q     <= '0;
            spare_sz_q <= '0;
            step_q     <= '0;
            parity_q   <= '0;
            skip_q     <= '0;
            cnt_q      <= '0;
        end else if (take_start) begin
            spare_q    <= spare_mode;
            page_q     <= page_size;
            spare_sz_q <= spare_size;
            step_q     <= step_size;
            parity_q   <= parity_bytes;
            skip_q     <= COL_W'(skip_count);
            cnt_q      <= step_count;
        end
    end

    scm_chunk_gen #(
        .COL_W(COL_W),
        .CNT_W(CNT_W)
    ) u_chunk_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .load            (take_start),
        .advance         (advance),
        .spare_mode      (spare_q),
        .page_sz         (page_q),
        .spare_sz        (spare_sz_q),
        .step_sz         (step_q),
        .parity_sz       (parity_q),
        .step_cnt        (cnt_q),
        .skip_sz         (skip_q),
        .load_step_sz    (step_size),
        .load_spare_mode (spare_mode),
        .raw_pos         (raw_pos),
        .raw_len         (raw_len),
        .is_last         (is_last)
    );

    scm_split #(
        .COL_W(COL_W)
    ) u_split (
        .pos      (raw_pos),
        .len      (raw_len),
        .page_sz  (page_q),
        .skip_sz  (skip_q),
        .head_col (head_col),
        .head_len (head_len),
        .tail_col (tail_col),
        .tail_len (tail_len),
        .straddle (straddle)
    );

    // Next state and step advance: marker, head, optional tail, then the next step or done.
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (spare_mode)              state_d = ST_MARK;
                    else if (step_count == '0)   state_d = ST_DONE;
                    else                         state_d = ST_CHUNK;
                end
            end
            ST_MARK: begin
                if (accept) state_d = (cnt_q == '0) ? ST_DONE : ST_CHUNK;
            end
            ST_CHUNK: begin
                if (accept) begin
                    if (straddle) begin
                        state_d = ST_TAIL;
                    end else if (is_last) begin
                        state_d = ST_DONE;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (accept) begin
                    if (is_last) begin
                        state_d = ST_DONE;
                    end else begin
                        advance = 1'b1;
                        state_d = ST_CHUNK;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output mux: marker region, head (or whole chunk), or tail.
    always_comb begin
        seg_valid = 1'b0;
        seg_col   = '0;
        seg_len   = '0;
        unique case (state_q)
            ST_MARK: begin
                seg_valid = 1'b1;
                seg_col   = page_q;
                seg_len   = skip_q;
            end
            ST_CHUNK: begin
                seg_valid = 1'b1;
                seg_col   = head_col;
                seg_len   = head_len;
            end
            ST_TAIL: begin
                seg_valid = 1'b1;
                seg_col   = tail_col;
                seg_len   = tail_len;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

    // A stalled segment holds its value until it is accepted.
    assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_col) && $stable(seg_len))
        else $error("stalled segment changed");

    // done is a single-cycle pulse with no segment beside it.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !seg_valid)
        else $error("segment valid during done");

    // No segment that starts in the main area runs past its end.
    assert_main_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && (seg_col < page_q) |->
            (SUM_W'(seg_col) + SUM_W'(seg_len)) <= SUM_W'(page_q))
        else $error("segment crosses the main-area end");

    // Outside the marker segment, nothing in the spare area touches the marker bytes.
    assert_skip_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && (state_q != ST_MARK) && (seg_col >= page_q) |->
            SUM_W'(seg_col) >= (SUM_W'(page_q) + SUM_W'(skip_q)))
        else $error("segment overlaps the marker bytes");

    // A start while busy leaves the latched job untouched.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(spare_q) && $stable(page_q) && $stable(cnt_q))
        else $error("start accepted while busy");

endmodule

// File: tb/skip_column_mapper_bench.sv
`timescale 1ns/1ps
module skip_column_mapper_bench;

    localparam int COL_W  = 16;
    localparam int CNT_W  = 8;
    localparam int SKIP_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic              spare_mode;
    logic [COL_W-1:0]  page_size, spare_size, step_size, parity_bytes;
    logic [CNT_W-1:0]  step_count;
    logic [SKIP_W-1:0] skip_count;
    logic              busy, seg_valid, seg_ready, done;
    logic [COL_W-1:0]  seg_col, seg_len;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int last_acc_cyc = 0;
    bit stall_en = 1'b0;

    int    q_col[$];
    int    q_len[$];
    string q_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    skip_column_mapper #(
        .COL_W(COL_W), .CNT_W(CNT_W), .SKIP_W(SKIP_W)
    ) u_skip_column_mapper (
        .clk(clk), .rst_n(rst_n), .start(start), .spare_mode(spare_mode),
        .page_size(page_size), .spare_size(spare_size), .step_size(step_size),
        .parity_bytes(parity_bytes), .step_count(step_count), .skip_count(skip_count),
        .busy(busy), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_col(seg_col), .seg_len(seg_len), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Split one raw chunk into expected segments per R2/R3.
    task automatic push_chunk(input int pos, input int len, input int w, input int k,
                              input string tag);
        if (pos >= w) begin
            q_col.push_back(pos + k); q_len.push_back(len); q_tag.push_back({tag, "/R2"});
        end else if (pos + len > w) begin
            q_col.push_back(pos);     q_len.push_back(w - pos);       q_tag.push_back({tag, "/R3"});
            q_col.push_back(w + k);   q_len.push_back(len - (w - pos)); q_tag.push_back({tag, "/R3"});
        end else begin
            q_col.push_back(pos); q_len.push_back(len); q_tag.push_back(tag);
        end
    endtask

    // Driver: model the job, push expected segments, start it, check done timing.
    task automatic run_job(input bit sm, input int w, input int o, input int s,
                           input int p, input int n, input int k,
                           input bit stall, input bit poke);
        int start_cyc;
        int nexp;
        int waited;
        if (sm) begin
            q_col.push_back(w); q_len.push_back(k); q_tag.push_back("R4");
        end
        for (int i = 0; i < n; i++) begin
            if (!sm) push_chunk(i * (s + p), s, w, k, "R1");
            else if (i == n - 1) push_chunk(s + i * (s + p), w + o - (s + i * (s + p)) - k, w, k, "R6");
            else push_chunk(s + i * (s + p), p, w, k, "R5");
        end
        nexp = q_col.size();
        @(negedge clk);
        stall_en     = stall;
        spare_mode   = sm;
        page_size    = COL_W'(w);
        spare_size   = COL_W'(o);
        step_size    = COL_W'(s);
        parity_bytes = COL_W'(p);
        step_count   = CNT_W'(n);
        skip_count   = SKIP_W'(k);
        start        = 1'b1;
        start_cyc    = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (poke) begin
            // R9: a second start with other geometry while busy must change nothing.
            @(negedge clk);
            spare_mode = ~sm;
            page_size  = COL_W'(w + 8);
            step_count = CNT_W'(n + 2);
            skip_count = SKIP_W'(k + 3);
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            chk(1'b0, "R8", "done never seen", 0, 1);
        end else begin
            chk(cyc == ((nexp == 0) ? start_cyc + 1 : last_acc_cyc + 1), "R8",
                "done cycle", cyc, (nexp == 0) ? start_cyc + 1 : last_acc_cyc + 1);
            chk(q_col.size() == 0, "R8", "segments left at done", q_col.size(), 0);
            @(negedge clk);
            chk(!done && !busy, "R8", "done/busy after pulse", {done, busy}, 0);
        end
        q_col.delete(); q_len.delete(); q_tag.delete();
        repeat (3) @(negedge clk);
        chk(!seg_valid, "R9", "extra segment after job", seg_valid, 0);
    endtask

    // Monitor: drives ready away from the edge, pops and compares on each handshake.
    initial begin
        bit stalled_prev = 1'b0;
        int prev_col = 0;
        int prev_len = 0;
        bit rdy;
        seg_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                seg_ready = 1'b0;
                stalled_prev = 1'b0;
            end else begin
                if (stalled_prev)
                    chk(seg_valid && seg_col == prev_col && seg_len == prev_len, "R7",
                        "held segment column", seg_col, prev_col);
                rdy = stall_en ? ((cyc % 3) != 1) : 1'b1;
                seg_ready = rdy;
                if (seg_valid && rdy) begin
                    last_acc_cyc = cyc;
                    if (q_col.size() == 0) begin
                        chk(1'b0, "R9", "unexpected segment column", seg_col, -1);
                    end else begin
                        string t;
                        int ec, el;
                        ec = q_col.pop_front(); el = q_len.pop_front(); t = q_tag.pop_front();
                        chk(seg_col == ec, t, "segment column", seg_col, ec);
                        chk(seg_len == el, t, "segment length", seg_len, el);
                    end
                end
                stalled_prev = seg_valid && !rdy;
                prev_col = seg_col;
                prev_len = seg_len;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        rst_n = 1'b0; start = 1'b0; spare_mode = 1'b0;
        page_size = '0; spare_size = '0; step_size = '0; parity_bytes = '0;
        step_count = '0; skip_count = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !seg_valid && !done, "R11", "outputs in reset", {busy, seg_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !seg_valid && !done, "R11", "outputs after reset", {busy, seg_valid, done}, 0);

        // R1, R3: payload, last chunk straddles (60,4)+(66,12)
        run_job(1'b0, 64, 16, 16, 4, 4, 2, 1'b0, 1'b0);
        // R2: chunks starting exactly at and beyond the page end
        run_job(1'b0, 32, 32, 8, 8, 4, 2, 1'b1, 1'b0);
        // R1: a chunk ending exactly at the page end is not split
        run_job(1'b0, 32, 32, 12, 8, 3, 4, 1'b0, 1'b0);
        // R4, R5, R6: spare mode, last region in spare area
        run_job(1'b1, 64, 16, 16, 4, 4, 2, 1'b0, 1'b0);
        // R5, R3: a middle parity region straddles, stalled
        run_job(1'b1, 64, 32, 14, 10, 4, 2, 1'b1, 1'b0);
        // R6, R3: the stretched last region straddles; R9 start while busy
        run_job(1'b1, 64, 32, 14, 10, 3, 2, 1'b1, 1'b1);
        // R9: payload job with a mid-job start poke
        run_job(1'b0, 64, 16, 16, 4, 4, 2, 1'b1, 1'b1);
        // R10: zero steps, payload gives no segment, spare gives only the marker
        run_job(1'b0, 64, 16, 16, 4, 0, 2, 1'b0, 1'b0);
        run_job(1'b1, 64, 16, 16, 4, 0, 6, 1'b1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule